// File: doc/BRIEF.md
# Ethernet MAC Transmit Buffer Controller

This block is the transmit half of a 10 Mbps Ethernet MAC, clocked at the serial bit rate so that one bit leaves per clock. A memory-side port writes frame bytes, one per cycle, into a local byte store. The final byte of each frame is tagged with an end-of-frame flag. A burst-room output tells the writer when a whole 16-byte burst (four 32-bit words) will fit. On the line side, the block drives a serial data bit and a transmit-enable strobe toward an external transceiver. It watches a collision input from that transceiver.

A frame is not started until a full collision window of data (64 bytes) is buffered, or until the frame's end-of-frame byte has arrived. Those first 64 bytes stay in the store until they have gone out without a collision. A retry therefore replays the frame from the store, and the writer never refetches data. The block generates the preamble and start delimiter and keeps the interframe gap. After a collision it sends a jam pattern, backs off by a random number of slot times and retries, giving up after 16 attempts. Each finished or abandoned frame leaves a status word that clears when software reads it. The frame check sequence is expected to be part of the written data.

Top module: `mac_tx_ctrl`

## Requirements
- R1: A frame starts only while `tx_en_i` is high; writes are accepted whatever its level, and a frame held back by it goes out once it rises.
- R2: With `tx_en_i` high, transmission starts only once at least HOLD_BYTES (64) unsent bytes are stored or an end-of-frame byte is stored.
- R3: A write is refused when DEPTH bytes are stored. `room_o` is high exactly when at least BURST_BYTES (16) entries are free, counting bytes still held for retry as occupied.
- R4: Every attempt begins with 64 bit times of `txen_o` high carrying seven 0x55 bytes and then 0xD5, each byte least significant bit first.
- R5: Data bytes follow the start delimiter least significant bit first, with no gaps. The attempt ends after bit 7 of the end-of-frame byte, and the status then becomes done=1, excess=0, count = collisions of that frame.
- R6: Between the end of one burst of `txen_o` and the next, `txen_o` stays low for at least IFG_BITS (96) cycles, and for exactly 96 when a ready frame is waiting.
- R7: `col_i` high during the preamble or while data byte 0..63 is being sent ends that cycle's bit. The next cycle starts a jam of JAM_BITS (32) cycles with `txen_o` high and `txd_o` alternating 1,0 starting with 1. The retry resends the frame from its first byte.
- R8: `col_i` while data byte 64 or later is being sent, or while idle, is ignored and is not counted.
- R9: After the n-th jam the line stays low for (L & (2^min(n,10) - 1)) * SLOT_BITS cycles plus the interframe gap. L is a 10-bit LFSR that resets to 0x3FF and shifts left each clock, taking in bit9 XOR bit6 at bit 0; its value in the jam's last cycle is used.
- R10: When the 16th collision's jam ends, the status becomes done=1, excess=1, count=16. The frame's remaining bytes are discarded through its end-of-frame byte without being sent, and the next frame then transmits normally.
- R11: `stat_o` is {done (bit 6), excess (bit 5), count (bits 4:0)}. A cycle with `stat_rd_i` high clears it on the next edge, unless a frame finishes in that same cycle, in which case the new status wins.
- R12: During and right after reset, `txen_o` and `txd_o` are low, `stat_o` is zero and `room_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable control bit |
| wr_valid_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Byte written |
| wr_eof_i | input | 1 | Written byte is the last of its frame |
| room_o | output | 1 | A full write burst fits |
| txd_o | output | 1 | Serial data toward the transceiver |
| txen_o | output | 1 | Transmit enable toward the transceiver |
| col_i | input | 1 | Collision indication from the transceiver |
| stat_rd_i | input | 1 | Status read strobe (clears status) |
| stat_o | output | 7 | Status: done, excess, collision count |

## Verification
The bench steers collisions into the preamble, into the first data bytes and past byte 64. A design with the wrong window would count a late collision, or let an early one through and corrupt the frame. It also holds a frame back at 63 buffered bytes: a threshold off by one would start the line early. It then runs a 150-byte frame through a 128-byte store, so a design that freed held bytes too soon would replay garbage, and one that never freed them would stall the writer forever. Sixteen back-to-back collisions drive the give-up path, where a design that failed to discard the abandoned bytes would send them ahead of the next frame. The backoff lengths are predicted exactly from the LFSR, so a wrong mask or slot count shows up as a shifted retry.

// File: rtl/mac_tx_pkg.sv
package mac_tx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_DATA,
    S_JAM,
    S_BACK,
    S_DROP,
    S_GAP
  } tx_state_e;
endpackage

// File: rtl/mac_tx_store.sv
module mac_tx_store #(
  parameter int DEPTH       = 128,
  parameter int BURST_BYTES = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [7:0]    wr_data_i,
  input  logic          wr_eof_i,
  input  logic [PW-1:0] rd_ptr_i,
  input  logic [PW-1:0] base_ptr_i,
  input  logic          eof_done_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_eof_o,
  output logic [PW-1:0] used_o,
  output logic [PW-1:0] ahead_o,
  output logic          eof_pend_o,
  output logic          room_o
);
  logic [8:0]    mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q;
  logic [PW-1:0] eof_cnt_q;
  logic          full, wr_fire;

  assign used_o   = wr_ptr_q - base_ptr_i;
  assign ahead_o  = wr_ptr_q - rd_ptr_i;
  assign full     = (used_o == PW'(DEPTH));
  assign wr_fire  = wr_valid_i && !full;
  assign room_o   = ((PW+1)'(DEPTH) - {1'b0, used_o}) >= (PW+1)'(BURST_BYTES);
  assign eof_pend_o = (eof_cnt_q != '0);
  assign {rd_eof_o, rd_data_o} = mem_q[rd_ptr_i[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (wr_fire) mem_q[wr_ptr_q[AW-1:0]] <= {wr_eof_i, wr_data_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      eof_cnt_q <= '0;
    end else begin
      if (wr_fire) wr_ptr_q <= wr_ptr_q + 1'b1;
      case ({wr_fire && wr_eof_i, eof_done_i})
        2'b10:   eof_cnt_q <= eof_cnt_q + 1'b1;
        2'b01:   eof_cnt_q <= eof_cnt_q - 1'b1;
        default: eof_cnt_q <= eof_cnt_q;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_o <= PW'(DEPTH));
  p_eof_known_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_done_i |-> eof_cnt_q != '0);
endmodule

// File: rtl/mac_tx_lfsr.sv
module mac_tx_lfsr #(
  parameter int W     = 10,
  parameter int TAP_A = 9,
  parameter int TAP_B = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] lfsr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_o <= '1;
    else         lfsr_o <= {lfsr_o[W-2:0], lfsr_o[TAP_A] ^ lfsr_o[TAP_B]};
  end

  p_lfsr_live_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_o != '0);
endmodule

// File: rtl/mac_tx_ctrl.sv
module mac_tx_ctrl
  import mac_tx_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int BURST_BYTES = 16,
  parameter int HOLD_BYTES  = 64,
  parameter int IFG_BITS    = 96,
  parameter int JAM_BITS    = 32,
  parameter int MAX_TRY     = 16,
  parameter int SLOT_BITS   = 512,
  parameter int BO_LIMIT    = 10,
  localparam int PW  = $clog2(DEPTH) + 1,
  localparam int TW  = $clog2(MAX_TRY + 1),
  localparam int IW  = $clog2(HOLD_BYTES) + 1,
  localparam int BCW = $clog2((JAM_BITS > 64) ? JAM_BITS : 64),
  localparam int CW  = $clog2((2**BO_LIMIT) * SLOT_BITS + IFG_BITS + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_en_i,
  input  logic          wr_valid_i,
  input  logic [7:0]    wr_data_i,
  input  logic          wr_eof_i,
  output logic          room_o,
  output logic          txd_o,
  output logic          txen_o,
  input  logic          col_i,
  input  logic          stat_rd_i,
  output logic [TW+1:0] stat_o
);
  tx_state_e      state_q;
  logic [BCW-1:0] bit_cnt_q;
  logic [CW-1:0]  cnt_q;
  logic [IW-1:0]  byte_idx_q;
  logic [TW-1:0]  tries_q;
  logic [PW-1:0]  rd_ptr_q, base_ptr_q;
  logic [PW-1:0]  used, ahead;
  logic [7:0]     rd_data;
  logic           rd_eof, eof_pend, eof_done;
  logic           can_go, col_ok, byte_end, stat_upd;
  logic [TW+1:0]  stat_nx;
  logic [BO_LIMIT-1:0] lfsr, bo_mask;
  logic [CW-1:0]  bo_wait;

  mac_tx_store #(.DEPTH(DEPTH), .BURST_BYTES(BURST_BYTES)) u_store (
    .clk_i, .rst_ni, .wr_valid_i, .wr_data_i, .wr_eof_i,
    .rd_ptr_i(rd_ptr_q), .base_ptr_i(base_ptr_q), .eof_done_i(eof_done),
    .rd_data_o(rd_data), .rd_eof_o(rd_eof), .used_o(used), .ahead_o(ahead),
    .eof_pend_o(eof_pend), .room_o(room_o)
  );

  mac_tx_lfsr #(.W(BO_LIMIT)) u_lfsr (.clk_i, .rst_ni, .lfsr_o(lfsr));

  // backoff window grows with attempt number, capped at BO_LIMIT bits
  always_comb begin
    for (int i = 0; i < BO_LIMIT; i++) bo_mask[i] = (TW'(i) < tries_q);
  end
  assign bo_wait = CW'(lfsr & bo_mask) * CW'(SLOT_BITS);

  assign can_go   = tx_en_i && ((ahead >= PW'(HOLD_BYTES)) || eof_pend);
  assign col_ok   = col_i && ((state_q == S_PRE) ||
                    (state_q == S_DATA && byte_idx_q < IW'(HOLD_BYTES)));
  assign byte_end = (state_q == S_DATA) && !col_ok && (bit_cnt_q == BCW'(7));
  assign eof_done = (byte_end && rd_eof) ||
                    (state_q == S_DROP && ahead != '0 && rd_eof);

  always_comb begin
    stat_upd = 1'b0;
    stat_nx  = '0;
    if (byte_end && rd_eof) begin
      stat_upd = 1'b1;
      stat_nx  = {1'b1, 1'b0, tries_q};
    end else if (state_q == S_JAM && bit_cnt_q == BCW'(JAM_BITS-1) &&
                 tries_q == TW'(MAX_TRY)) begin
      stat_upd = 1'b1;
      stat_nx  = {1'b1, 1'b1, tries_q};
    end
  end

  always_comb begin
    txen_o = 1'b0;
    txd_o  = 1'b0;
    case (state_q)
      S_PRE:  begin txen_o = 1'b1; txd_o = (bit_cnt_q == BCW'(63)) | ~bit_cnt_q[0]; end
      S_DATA: begin txen_o = 1'b1; txd_o = rd_data[bit_cnt_q[2:0]]; end
      S_JAM:  begin txen_o = 1'b1; txd_o = ~bit_cnt_q[0]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      bit_cnt_q  <= '0;
      cnt_q      <= '0;
      byte_idx_q <= '0;
      tries_q    <= '0;
      rd_ptr_q   <= '0;
      base_ptr_q <= '0;
    end else begin
      if (col_ok) begin
        state_q   <= S_JAM;
        bit_cnt_q <= '0;
        tries_q   <= tries_q + 1'b1;
        rd_ptr_q  <= base_ptr_q;
      end else begin
        case (state_q)
          S_IDLE: if (can_go) begin
            state_q   <= S_PRE;
            bit_cnt_q <= '0;
          end
          S_GAP: if (cnt_q == CW'(IFG_BITS-1)) begin
            state_q   <= can_go ? S_PRE : S_IDLE;
            bit_cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
          S_PRE: if (bit_cnt_q == BCW'(63)) begin
            state_q    <= S_DATA;
            bit_cnt_q  <= '0;
            byte_idx_q <= '0;
          end else bit_cnt_q <= bit_cnt_q + 1'b1;
          S_DATA: if (byte_end) begin
            rd_ptr_q  <= rd_ptr_q + 1'b1;
            bit_cnt_q <= '0;
            // bytes past the collision window no longer need replay
            if (byte_idx_q >= IW'(HOLD_BYTES-1) || rd_eof) base_ptr_q <= rd_ptr_q + 1'b1;
            if (byte_idx_q < IW'(HOLD_BYTES)) byte_idx_q <= byte_idx_q + 1'b1;
            if (rd_eof) begin
              state_q <= S_GAP;
              cnt_q   <= '0;
              tries_q <= '0;
            end
          end else bit_cnt_q <= bit_cnt_q + 1'b1;
          S_JAM: if (bit_cnt_q == BCW'(JAM_BITS-1)) begin
            if (tries_q == TW'(MAX_TRY)) begin
              state_q <= S_DROP;
              tries_q <= '0;
            end else if (bo_wait == '0) begin
              state_q <= S_GAP;
              cnt_q   <= '0;
            end else begin
              state_q <= S_BACK;
              cnt_q   <= bo_wait;
            end
          end else bit_cnt_q <= bit_cnt_q + 1'b1;
          S_BACK: if (cnt_q == CW'(1)) begin
            state_q <= S_GAP;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q - 1'b1;
          S_DROP: if (ahead != '0) begin
            rd_ptr_q   <= rd_ptr_q + 1'b1;
            base_ptr_q <= rd_ptr_q + 1'b1;
            if (rd_eof) begin
              state_q <= S_GAP;
              cnt_q   <= '0;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stat_o <= '0;
    else if (stat_upd)  stat_o <= stat_nx;
    else if (stat_rd_i) stat_o <= '0;
  end

  // cycles with the line idle since it last dropped, for the gap check
  logic [CW-1:0] low_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          low_cnt_q <= CW'(IFG_BITS);
    else if (txen_o)                      low_cnt_q <= '0;
    else if (low_cnt_q < CW'(IFG_BITS))   low_cnt_q <= low_cnt_q + 1'b1;
  end

  p_start_gated_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txen_o) |-> $past(tx_en_i));
  p_hold_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txen_o) |-> $past(ahead >= PW'(HOLD_BYTES) || eof_pend));
  p_gap_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txen_o) |-> low_cnt_q >= CW'(IFG_BITS));
  p_rewind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == S_JAM) |-> rd_ptr_q == base_ptr_q);
  p_late_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DATA && byte_idx_q >= IW'(HOLD_BYTES)) |-> base_ptr_q == rd_ptr_q);
  p_held_in_store_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ptr_q - base_ptr_q) <= used);
  p_try_cap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tries_q <= TW'(MAX_TRY));
  p_stat_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !stat_upd) |=> stat_o == '0);
endmodule

// File: tb/tb_mac_tx_ctrl.sv
module tb_mac_tx_ctrl;
  localparam int DEPTH = 128, BURST = 16, HOLD = 64, IFG = 96, JAM = 32;
  localparam int MAXT = 16, SLOT = 2, BOL = 10;
  localparam int M_IDLE = 0, M_PRE = 1, M_DATA = 2, M_JAM = 3, M_BACK = 4, M_DROP = 5, M_GAP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b0, wr_valid = 1'b0, wr_eof = 1'b0, col = 1'b0, stat_rd = 1'b0;
  logic [7:0] wr_data = '0;
  logic room, txd, txen;
  logic [6:0] stat;

  always #2 clk = ~clk;

  mac_tx_ctrl #(.DEPTH(DEPTH), .BURST_BYTES(BURST), .HOLD_BYTES(HOLD), .IFG_BITS(IFG),
                .JAM_BITS(JAM), .MAX_TRY(MAXT), .SLOT_BITS(SLOT), .BO_LIMIT(BOL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_eof_i(wr_eof), .room_o(room), .txd_o(txd), .txen_o(txen), .col_i(col),
    .stat_rd_i(stat_rd), .stat_o(stat));

  int n_chk = 0, n_fail = 0, rises = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit [8:0] q[$];
  int mst, mbit, mcnt, midx, mtry, mrd, mlfsr, mstat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      mst = M_IDLE; mbit = 0; mcnt = 0; midx = 0; mtry = 0; mrd = 0;
      mlfsr = 10'h3FF; mstat = 0;
    end else begin
      int ahead, eofs, sz0, w, k, nst;
      bit go, colok, upd;
      sz0 = q.size();
      ahead = sz0 - mrd;
      eofs = 0;
      foreach (q[i]) if (q[i][8]) eofs++;
      go = tx_en && (ahead >= HOLD || eofs > 0);
      colok = col && (mst == M_PRE || (mst == M_DATA && midx < HOLD));
      upd = 0; nst = 0;
      if (colok) begin
        mst = M_JAM; mbit = 0; mtry++; mrd = 0;
      end else begin
        case (mst)
          M_IDLE: if (go) begin mst = M_PRE; mbit = 0; end
          M_GAP: if (mcnt == IFG-1) begin mst = go ? M_PRE : M_IDLE; mbit = 0; end
                 else mcnt++;
          M_PRE: if (mbit == 63) begin mst = M_DATA; mbit = 0; midx = 0; end
                 else mbit++;
          M_DATA: if (mbit == 7) begin
            bit e;
            e = q[mrd][8];
            mbit = 0;
            if (midx >= HOLD-1 || e) begin
              for (int i = 0; i <= mrd; i++) void'(q.pop_front());
              mrd = 0;
            end else mrd++;
            if (midx < HOLD) midx++;
            if (e) begin
              upd = 1; nst = 64 | mtry;
              mst = M_GAP; mcnt = 0; mtry = 0;
            end
          end else mbit++;
          M_JAM: if (mbit == JAM-1) begin
            if (mtry == MAXT) begin
              upd = 1; nst = 64 | 32 | mtry;
              mst = M_DROP; mtry = 0;
            end else begin
              k = (mtry > BOL) ? BOL : mtry;
              w = (mlfsr & ((1 << k) - 1)) * SLOT;
              if (w == 0) begin mst = M_GAP; mcnt = 0; end
              else begin mst = M_BACK; mcnt = w; end
            end
          end else mbit++;
          M_BACK: if (mcnt == 1) begin mst = M_GAP; mcnt = 0; end
                  else mcnt--;
          M_DROP: if (ahead > 0) begin
            bit [8:0] b;
            b = q.pop_front();
            if (b[8]) begin mst = M_GAP; mcnt = 0; end
          end
          default: ;
        endcase
      end
      if (wr_valid && sz0 < DEPTH) q.push_back({wr_eof, wr_data});
      if (upd) mstat = nst;
      else if (stat_rd) mstat = 0;
      mlfsr = ((mlfsr << 1) & 10'h3FF) | (((mlfsr >> 9) ^ (mlfsr >> 6)) & 1);
    end
  end

  // per-cycle comparison against the model, away from the active edge
  bit prev_txen = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit et, ed;
      string tg;
      et = (mst == M_PRE || mst == M_DATA || mst == M_JAM);
      case (mst)
        M_PRE:  begin ed = (mbit == 63) ? 1'b1 : (mbit % 2 == 0); tg = "R4"; end
        M_DATA: begin ed = q[mrd][mbit]; tg = "R5"; end
        M_JAM:  begin ed = (mbit % 2 == 0); tg = "R7"; end
        M_BACK: begin ed = 0; tg = "R9"; end
        M_GAP:  begin ed = 0; tg = "R6"; end
        M_DROP: begin ed = 0; tg = "R10"; end
        default: begin ed = 0; tg = "R2"; end
      endcase
      check(txen == et, {tg, " txen"}, txen, et);
      check(txd == ed, {tg, " txd"}, txd, ed);
      check(room == ((DEPTH - q.size()) >= BURST), "R3 room", room, (DEPTH - q.size()) >= BURST);
      check(stat == 7'(mstat), "R11 stat", stat, mstat);
      if (txen && !prev_txen) rises++;
      prev_txen = txen;
    end
  end

  task automatic write_frame(input int len, input int seed, input int hold_at);
    for (int i = 0; i < len; i++) begin
      if (hold_at != 0 && i == hold_at) begin
        int r0;
        wr_valid = 0;
        r0 = rises;
        repeat (150) @(negedge clk);
        check(rises == r0, "R2 held below threshold", rises, r0);
      end
      if (i % BURST == 0) begin
        wr_valid = 0;
        while (!room) @(negedge clk);
      end
      wr_valid = 1;
      wr_data = 8'((seed + i * 7) & 255);
      wr_eof = (i == len - 1);
      @(negedge clk);
    end
    wr_valid = 0;
    wr_eof = 0;
  endtask

  task automatic wait_done(input int exp, input string tag);
    while (!stat[6]) @(negedge clk);
    check(stat == 7'(exp), tag, stat, exp);
    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0;
    check(stat == 0, "R11 cleared on read", stat, 0);
  endtask

  task automatic wait_start();
    while (txen) @(negedge clk);
    while (!txen) @(negedge clk);
  endtask

  task automatic pulse_col();
    col = 1;
    @(negedge clk);
    col = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txen == 0, "R12 reset txen", txen, 0);
    check(txd == 0, "R12 reset txd", txd, 0);
    check(stat == 0, "R12 reset stat", stat, 0);
    check(room == 1, "R12 reset room", room, 1);
    rst_n = 1;
    @(negedge clk);
    check(stat == 0 && !txen, "R12 after reset", stat, 0);

    // R1: frame buffered while disabled must wait
    write_frame(10, 1, 0);
    repeat (300) @(negedge clk);
    check(rises == 0, "R1 no start while disabled", rises, 0);
    tx_en = 1;
    wait_done(64, "R1 held frame sent, R5 status");

    // R2: 100-byte frame paused at 63 bytes
    write_frame(100, 33, 63);
    wait_done(64, "R2 status");

    // R6: two short frames back to back
    write_frame(20, 5, 0);
    write_frame(30, 9, 0);
    wait_done(64, "R6 first frame");
    wait_done(64, "R6 second frame");

    // R3: frame longer than the store
    write_frame(150, 77, 0);
    wait_done(64, "R3 long frame status");

    // R7, R8: early, mid and late collisions
    tx_en = 0;
    write_frame(80, 121, 0);
    tx_en = 1;
    wait_start();
    repeat (20) @(negedge clk);
    pulse_col();
    wait_start();
    repeat (64 + 8 * 10 + 3) @(negedge clk);
    pulse_col();
    wait_start();
    repeat (64 + 8 * 70 + 3) @(negedge clk);
    pulse_col();
    wait_done(66, "R8 late collision not counted");

    // R9, R10: sixteen collisions then give up
    tx_en = 0;
    write_frame(40, 200, 0);
    tx_en = 1;
    for (int k = 0; k < MAXT; k++) begin
      wait_start();
      repeat (5) @(negedge clk);
      pulse_col();
    end
    wait_done(112, "R10 excessive status");
    write_frame(12, 60, 0);
    wait_done(64, "R10 next frame after drop");

    repeat (200) @(negedge clk);
    summary();
  end
endmodule